// File: doc/BRIEF.md
# Power Management Timer and Event Register Block

This block is a small register file on an 8-bit wide, byte-addressed I/O port. It has a free-running timer that advances on a clock-enable pulse train of about 3.58 MHz. It also has one 32-bit word holding event flags and their enables, and one 32-bit control word. When the timer rolls over from all ones to zero, an event flag is latched. If the matching enable is set, a level interrupt is driven until software removes the cause.

The registers occupy a relocatable 64-byte window. Its base comes in on an input and is aligned by dropping the six low bits. An aligned base of zero turns the window off. Inside the window, address bits [5:2] select the word and bits [1:0] select the byte lane. Writing a one to the suspend bit of the control word produces a one-cycle strobe and is not stored.

Top module: `pm_event_regs`

## Requirements
- R1: After reset the timer, every event flag and every enable read as zero, the control word reads 32'h0000_0001, and irq, suspendStrobe and sleepType are all zero.
- R2: The timer is TMR_W bits wide (24 by default) and advances by exactly one on each clock where tickEn is high. It holds otherwise. It reads at word offset 8, and bits above TMR_W read as zero.
- R3: When the timer advances from all ones, it becomes zero and event flag bit 0 (offset 0, byte 0, bit 0) is set.
- R4: irq is high exactly while event flag bit 0 and enable bit 16 (offset 0, byte 2, bit 0) are both set. It is a level that stays up with no further ticks.
- R5: A byte write to offset 0 or 1 clears each event flag whose data bit is one and leaves the others unchanged.
- R6: A byte write to offset 2 or 3 loads the enable bits of that byte with the data, leaving the other enable byte unchanged.
- R7: If a rollover and a write-one-to-clear of flag 0 happen on the same clock, the flag ends up set.
- R8: A read of window byte address a returns bits [8*(a%4)+7 : 8*(a%4)] of the selected word.
- R9: The control word is written a byte at a time, and sleepType shows its bits [12:10]. Writing one to bit 13 (offset 5, data bit 5) raises suspendStrobe for exactly the next clock cycle. Bit 13 always reads back as zero.
- R10: The window base is baseAddr with its low six bits dropped. Addresses outside the window, or any access while the aligned base is zero, read as zero and change no register.
- R11: Word offsets other than 0, 4 and 8 inside the window read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer advance enable, pulsed at the timer rate |
| baseAddr | input | ADDR_W | Window base; low six bits ignored |
| busAddr | input | ADDR_W | Byte address of the current access |
| busWr | input | 1 | Write strobe for one clock |
| busWdata | input | 8 | Write data byte |
| busRdata | output | 8 | Read data byte (combinational from busAddr) |
| irq | output | 1 | Level interrupt from timer rollover |
| suspendStrobe | output | 1 | One-cycle pulse after a suspend request |
| sleepType | output | 3 | Sleep type field of the control word |

## Verification
A vector table first walks byte writes and reads across all four lanes of the event word and the control word, using unlike data patterns (0x5A, 0xC3, 0x1C) so that a lane swap or a wrong write rule shows up as a wrong byte. Directed runs then drive the timer with bursts of ticks and idle gaps. This separates advancing from holding, and takes it across the rollover both with and without the enable, so the flag and the interrupt are seen apart. A clear landing on the rollover clock checks which of set and clear wins. Accesses with a misaligned base, just past the window and with a zero base show whether decode masks and gates correctly.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EVT  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_TMR  = 2'd3
  } regSel_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic       wrEvt;
    logic       wrCtrl;
    regSel_e    sel;
    logic [1:0] lane;
  } pmStrobe_t;

  localparam int unsigned WORD_EVT  = 0;
  localparam int unsigned WORD_CTRL = 1;
  localparam int unsigned WORD_TMR  = 2;

  localparam logic [31:0] CTRL_RESET = 32'h0000_0001;
  localparam int unsigned SUSP_BIT   = 13;
  localparam int unsigned SLP_LSB    = 10;
  localparam int unsigned SLP_W      = 3;

endpackage

// File: rtl/pm_evt_decode.sv
module pm_evt_decode
  import pm_evt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_BITS = 6
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output pmStrobe_t         strobe
);
  localparam int unsigned IDX_W = WIN_BITS - 2;

  logic              baseValid;
  logic              inWindow;
  logic [IDX_W-1:0]  wordIdx;

  assign baseValid = |baseAddr[ADDR_W-1:WIN_BITS];
  assign inWindow  = baseValid &&
                     (busAddr[ADDR_W-1:WIN_BITS] == baseAddr[ADDR_W-1:WIN_BITS]);
  assign wordIdx   = busAddr[WIN_BITS-1:2];

  always_comb begin
    strobe      = '0;
    strobe.lane = busAddr[1:0];
    strobe.sel  = SEL_NONE;
    if (inWindow) begin
      if (wordIdx == IDX_W'(WORD_EVT))       strobe.sel = SEL_EVT;
      else if (wordIdx == IDX_W'(WORD_CTRL)) strobe.sel = SEL_CTRL;
      else if (wordIdx == IDX_W'(WORD_TMR))  strobe.sel = SEL_TMR;
    end
    strobe.wrEvt  = busWr && (strobe.sel == SEL_EVT);
    strobe.wrCtrl = busWr && (strobe.sel == SEL_CTRL);
  end

endmodule

// File: rtl/pm_evt_datapath.sv
module pm_evt_datapath
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  pmStrobe_t        strobe,
  input  logic [7:0]       busWdata,
  output logic [7:0]       busRdata,
  output logic             irq,
  output logic             suspendStrobe,
  output logic [SLP_W-1:0] sleepType
);
  localparam int unsigned HALF_W    = 16;
  localparam int unsigned HALF_LANE = HALF_W / 8;
  localparam int unsigned SUSP_LANE = SUSP_BIT / 8;
  localparam int unsigned SUSP_POS  = SUSP_BIT % 8;

  logic [TMR_W-1:0]  tmrCnt;
  logic [HALF_W-1:0] evtFlags, evtFlagsNext;
  logic [HALF_W-1:0] evtEnable, evtEnableNext;
  logic [31:0]       ctrlReg, ctrlNext;
  logic              rollOver;
  logic [31:0]       wordSel;

  assign rollOver = tickEn && (&tmrCnt);

  // byte-lane write rules per half of the event word, and control bytes
  always_comb begin
    evtFlagsNext  = evtFlags;
    evtEnableNext = evtEnable;
    ctrlNext      = ctrlReg;
    for (int ln = 0; ln < 4; ln++) begin
      if (strobe.lane == 2'(ln)) begin
        if (strobe.wrEvt) begin
          if (ln < HALF_LANE) evtFlagsNext[8*(ln%HALF_LANE) +: 8] =
                                evtFlags[8*(ln%HALF_LANE) +: 8] & ~busWdata;
          else                evtEnableNext[8*(ln%HALF_LANE) +: 8] = busWdata;
        end
        if (strobe.wrCtrl) ctrlNext[8*ln +: 8] = busWdata;
      end
    end
    if (rollOver) evtFlagsNext[0] = 1'b1;
    ctrlNext[SUSP_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrCnt        <= '0;
      evtFlags      <= '0;
      evtEnable     <= '0;
      ctrlReg       <= CTRL_RESET;
      suspendStrobe <= 1'b0;
    end else begin
      if (tickEn) tmrCnt <= tmrCnt + 1'b1;
      evtFlags      <= evtFlagsNext;
      evtEnable     <= evtEnableNext;
      ctrlReg       <= ctrlNext;
      suspendStrobe <= strobe.wrCtrl && (strobe.lane == 2'(SUSP_LANE)) &&
                       busWdata[SUSP_POS];
    end
  end

  always_comb begin
    case (strobe.sel)
      SEL_EVT:  wordSel = {evtEnable, evtFlags};
      SEL_CTRL: wordSel = ctrlReg;
      SEL_TMR:  wordSel = 32'(tmrCnt);
      default:  wordSel = '0;
    endcase
  end

  assign busRdata  = 8'(wordSel >> {strobe.lane, 3'b000});
  assign irq       = evtFlags[0] && evtEnable[0];
  assign sleepType = ctrlReg[SLP_LSB +: SLP_W];

endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
  import pm_evt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned TMR_W    = 24,
  parameter int unsigned WIN_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              irq,
  output logic              suspendStrobe,
  output logic [2:0]        sleepType
);
  pmStrobe_t strobe;

  pm_evt_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) uDec (
    .baseAddr(baseAddr),
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobe  (strobe)
  );

  pm_evt_datapath #(.TMR_W(TMR_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .tickEn       (tickEn),
    .strobe       (strobe),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .irq          (irq),
    .suspendStrobe(suspendStrobe),
    .sleepType    (sleepType)
  );

endmodule

// File: rtl/pm_event_regs_chk.sv
module pm_event_regs_chk
  import pm_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] busAddr,
  input pmStrobe_t         strobe,
  input logic [7:0]        busRdata,
  input logic              irq,
  input logic              suspendStrobe
);
  AST_NO_SEL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel == SEL_NONE) |-> (busRdata == 8'h00)); // R10

  AST_SUSP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    suspendStrobe |-> $past(strobe.wrCtrl)); // R9

  AST_SUSP_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (suspendStrobe && !strobe.wrCtrl) |=> !suspendStrobe); // R9

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(tickEn) || $past(strobe.wrEvt))); // R4

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(strobe.wrEvt)); // R5

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.sel == SEL_TMR) && ($past(strobe.sel) == SEL_TMR) &&
     ($past(busAddr) == busAddr) && !$past(tickEn)) |-> $stable(busRdata)); // R2

endmodule

bind pm_event_regs pm_event_regs_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .tickEn       (tickEn),
  .busAddr      (busAddr),
  .strobe       (strobe),
  .busRdata     (busRdata),
  .irq          (irq),
  .suspendStrobe(suspendStrobe)
);

// File: tb/tb_pm_event_regs.sv
module tb_pm_event_regs;
  localparam int unsigned TW = 10;
  localparam logic [15:0] BASE_IN = 16'h1257;
  localparam logic [15:0] BASE    = 16'h1240;
  localparam int NV = 14;
  // {isWrite, offset, data, expected, requirement}
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00, 8'h00, 4'd1},   // R1 flags
    {1'b0, 8'h04, 8'h00, 8'h01, 4'd1},   // R1 control reset value
    {1'b0, 8'h02, 8'h00, 8'h00, 4'd1},   // R1 enables
    {1'b1, 8'h02, 8'h5A, 8'h00, 4'd6},
    {1'b0, 8'h02, 8'h00, 8'h5A, 4'd6},   // R6
    {1'b1, 8'h03, 8'hC3, 8'h00, 4'd6},
    {1'b0, 8'h03, 8'h00, 8'hC3, 4'd6},   // R6
    {1'b0, 8'h02, 8'h00, 8'h5A, 4'd8},   // R8 lane 2 still intact
    {1'b1, 8'h05, 8'h1C, 8'h00, 4'd9},
    {1'b0, 8'h05, 8'h00, 8'h1C, 4'd9},   // R9
    {1'b0, 8'h04, 8'h00, 8'h01, 4'd8},   // R8
    {1'b1, 8'h30, 8'hFF, 8'h00, 4'd11},
    {1'b0, 8'h30, 8'h00, 8'h00, 4'd11},  // R11
    {1'b0, 8'h0B, 8'h00, 8'h00, 4'd2}    // R2 top timer byte
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [15:0] baseAddr = BASE_IN;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        irq;
  logic        suspendStrobe;
  logic [2:0]  sleepType;

  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  pm_event_regs #(.TMR_W(TW)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .baseAddr(baseAddr),
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq), .suspendStrobe(suspendStrobe),
    .sleepType(sleepType)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [28:0] e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 suspendStrobe", {7'd0, suspendStrobe}, 8'h00);
    check("R1 sleepType", {5'd0, sleepType}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      e = VEC[i];
      if (e[28]) wr(BASE + {8'h00, e[27:20]}, e[19:12]);
      else begin
        rd(BASE + {8'h00, e[27:20]}, v);
        check($sformatf("R%0d vector %0d", e[3:0], i), v, e[11:4]);
      end
    end
    check("R9 sleepType", {5'd0, sleepType}, 8'h07);

    // R9 suspend strobe
    wr(BASE + 16'h05, 8'h20);
    check("R9 strobe high", {7'd0, suspendStrobe}, 8'h01);
    @(negedge clk); #1;
    check("R9 strobe low", {7'd0, suspendStrobe}, 8'h00);
    rd(BASE + 16'h05, v);
    check("R9 bit13 reads zero", v, 8'h00);

    // R10 window decode
    rd(BASE + 16'h44, v);
    check("R10 past window", v, 8'h00);
    wr(BASE + 16'h42, 8'hFF);
    rd(BASE + 16'h02, v);
    check("R10 write outside ignored", v, 8'h5A);
    baseAddr = 16'h003F;
    rd(16'h0004, v);
    check("R10 zero base read", v, 8'h00);
    rd(BASE + 16'h04, v);
    check("R10 disabled read", v, 8'h00);
    wr(16'h0002, 8'h77);
    wr(BASE + 16'h02, 8'h77);
    baseAddr = BASE_IN;
    rd(BASE + 16'h02, v);
    check("R10 disabled write ignored", v, 8'h5A);

    // R2 timer
    ticks(5);
    rd(BASE + 16'h08, v);
    check("R2 five ticks", v, 8'h05);
    repeat (3) @(negedge clk);
    rd(BASE + 16'h08, v);
    check("R2 hold", v, 8'h05);
    ticks(1018);
    rd(BASE + 16'h08, v);
    check("R8 timer lane0", v, 8'hFF);
    rd(BASE + 16'h09, v);
    check("R8 timer lane1", v, 8'h03);
    rd(BASE + 16'h0A, v);
    check("R2 upper bits zero", v, 8'h00);
    rd(BASE + 16'h00, v);
    check("R3 no flag before rollover", v, 8'h00);

    // R3 / R4 rollover with enable
    wr(BASE + 16'h02, 8'h01);
    check("R4 no irq yet", {7'd0, irq}, 8'h00);
    ticks(1);
    rd(BASE + 16'h08, v);
    check("R3 timer zero", v, 8'h00);
    rd(BASE + 16'h00, v);
    check("R3 flag set", v, 8'h01);
    check("R4 irq high", {7'd0, irq}, 8'h01);
    repeat (4) @(negedge clk); #1;
    check("R4 irq level", {7'd0, irq}, 8'h01);

    // R5 write-one-to-clear
    wr(BASE + 16'h00, 8'h00);
    rd(BASE + 16'h00, v);
    check("R5 zero keeps flag", v, 8'h01);
    wr(BASE + 16'h01, 8'hFF);
    rd(BASE + 16'h00, v);
    check("R5 other byte keeps flag", v, 8'h01);
    wr(BASE + 16'h00, 8'h01);
    rd(BASE + 16'h00, v);
    check("R5 one clears", v, 8'h00);
    check("R4 irq drops", {7'd0, irq}, 8'h00);

    // R4 gating by enable
    wr(BASE + 16'h02, 8'h00);
    ticks(1024);
    rd(BASE + 16'h00, v);
    check("R3 flag without enable", v, 8'h01);
    check("R4 masked irq", {7'd0, irq}, 8'h00);
    wr(BASE + 16'h02, 8'h01);
    check("R4 enable raises irq", {7'd0, irq}, 8'h01);
    rd(BASE + 16'h03, v);
    check("R6 upper enable byte kept", v, 8'hC3);
    wr(BASE + 16'h02, 8'h00);
    check("R4 disable drops irq", {7'd0, irq}, 8'h00);

    // R7 set wins over clear
    wr(BASE + 16'h00, 8'h01);
    ticks(1023);
    @(negedge clk);
    busAddr = BASE; busWdata = 8'h01; busWr = 1'b1; tickEn = 1'b1;
    @(negedge clk);
    busWr = 1'b0; tickEn = 1'b0;
    rd(BASE + 16'h00, v);
    check("R7 set priority", v, 8'h01);
    rd(BASE + 16'h08, v);
    check("R3 wrapped again", v, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule